// File: doc/BRIEF.md
# Multidimensional Element Index Remapper

The remapper turns the plain element counter of a vector loop into a reordered element index. Software loads up to four shape words, one per operand slot. Each shape word gives three dimension sizes and a nesting order. A start pulse opens a loop of a given vector length. Each later step pulse advances the loop by one element. For that step, every slot reports the index its operand should touch.

A slot holds three counters, named x, y and z. On each step the innermost counter in the slot's nesting order goes up by one. A counter that reaches its size returns to zero and carries into the next counter in the order. The reported index is x + y*X + z*X*Y, where X and Y are the x and y sizes. A 1D or 2D walk is set up by giving the unused dimensions a size of one. A slot that is not enabled reports the plain element number, so remapped and sequential operands can be mixed in one operation. A 4x4 by 4x4 matrix product needs 64 multiply-accumulate steps. It is walked with 4x4x4 shapes that use a different order for each operand.

Top module: `remap_top`

## Requirements
- R1: A cycle with `cfgWe` high stores `cfgData` into the shape register of slot `cfgSlot`. The shape word has these fields: x size minus one in bits 6:0, y size minus one in bits 13:7, z size minus one in bits 20:14, order code in bits 23:21, and the enable bit in bit 24. Bits 31:25 are ignored. All shape registers are zero after reset.
- R2: A `start` pulse stores `vlIn` and clears every slot's counters and the element number. The first step after a start reports element 0, and index 0 on every enabled slot. A start also restarts a loop that is still running.
- R3: Each accepted step sets `valid` high for exactly one cycle. `valid` rises in the cycle after the step. In that cycle `seqIdx` holds the element number of the step, counted from 0, and `remapIdx` holds one index per slot.
- R4: For an enabled slot, the reported index is x + y*X + z*X*Y. Here x, y and z are the counter values before the step, and each size is its field plus one. The result is cut to `IDXW` bits.
- R5: Order codes name the counters from innermost to outermost as follows: 0 is x,y,z; 1 is x,z,y; 2 is y,x,z; 3 is y,z,x; 4 is z,x,y; 5 is z,y,x. On a step the innermost counter increments. A counter that has reached its size minus one goes back to 0 and carries on to the next counter. The carry stops at the first counter that does not wrap.
- R6: A size field of 0 means a size of 1, so that counter stays at 0. When all three counters wrap, the walk starts over at index 0.
- R7: A slot whose enable bit is 0 reports `seqIdx` unchanged.
- R8: `done` is high, together with `valid`, for the step of element VL-1. Steps after that, and steps given when no loop was started or when VL is 0, are ignored: `valid` stays low and `seqIdx` keeps its value.
- R9: All four slots advance on the same step, each with its own shape and order.
- R10: Four slots with 4x4x4 shapes and different orders walk a 64-step matrix-multiply loop.
- R11: Order codes 6 and 7 behave like order code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for a shape register |
| cfgSlot | input | 2 | Slot selected by a write |
| cfgData | input | 32 | Shape word to write |
| start | input | 1 | Begins a loop and clears the counters |
| vlIn | input | IDXW (16) | Vector length, taken at start |
| step | input | 1 | Advances the loop by one element |
| valid | output | 1 | A result from the previous step is present |
| done | output | 1 | The result is for the last element |
| seqIdx | output | IDXW (16) | Element number of the result |
| remapIdx | output | 4*IDXW (64) | Slot s index in bits s*IDXW +: IDXW |

## Verification
The first pattern mixes shapes on purpose. It uses a 3x4 2D shape in x-first and y-first order, a disabled slot, and a 4x4x4 shape in reverse order, so that a wrong carry, a wrong stride or an ignored enable each give a different index. A 64-step run with four 4x4x4 orders checks the matrix walk. A run with unit-size dimensions that is longer than the shape checks the wrap back to zero. Further runs cover the spare order codes next to code 0, a restart during a loop, and steps given after the last element.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DIM_W = 7;
  localparam int SHAPE_W = 32;

  typedef struct packed {
    logic [6:0]       spare;
    logic             en;
    logic [2:0]       ord;
    logic [DIM_W-1:0] zM1;
    logic [DIM_W-1:0] yM1;
    logic [DIM_W-1:0] xM1;
  } shape_t;

  typedef struct packed {
    logic clr;
    logic adv;
    logic last;
  } strb_t;

  // packed {outer, middle, inner} dimension numbers (0=x,1=y,2=z)
  function automatic logic [5:0] permOf(input logic [2:0] ord);
    case (ord)
      3'd1:    permOf = {2'd1, 2'd2, 2'd0};
      3'd2:    permOf = {2'd2, 2'd0, 2'd1};
      3'd3:    permOf = {2'd0, 2'd2, 2'd1};
      3'd4:    permOf = {2'd1, 2'd0, 2'd2};
      3'd5:    permOf = {2'd0, 2'd1, 2'd2};
      default: permOf = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int IDXW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            step,
  input  logic [IDXW-1:0] vlIn,
  output strb_t           strb,
  output logic [IDXW-1:0] seqCnt,
  output logic [IDXW-1:0] seqIdx,
  output logic            valid,
  output logic            done
);
  logic            active;
  logic [IDXW-1:0] vlQ;

  always_comb begin
    strb.clr  = start;
    strb.adv  = step && active && !start;
    strb.last = strb.adv && (seqCnt == vlQ - IDXW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      vlQ    <= '0;
      seqCnt <= '0;
      seqIdx <= '0;
      valid  <= 1'b0;
      done   <= 1'b0;
    end else begin
      valid <= strb.adv;
      done  <= strb.last;
      if (strb.adv) seqIdx <= seqCnt;
      if (strb.clr) begin
        active <= (vlIn != '0);
        vlQ    <= vlIn;
        seqCnt <= '0;
      end else if (strb.adv) begin
        seqCnt <= seqCnt + IDXW'(1);
        if (strb.last) active <= 1'b0;
      end
    end
  end

  // R3
  step_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.adv |=> valid);
  // R8
  last_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> (done && valid));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |-> !strb.adv);
endmodule

// File: rtl/remap_slot.sv
module remap_slot
  import remap_pkg::*;
#(
  parameter int IDXW   = 16,
  parameter int SLOT_W = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [SHAPE_W-1:0] cfgData,
  input  strb_t             strb,
  input  logic [IDXW-1:0]   seqCnt,
  output logic [IDXW-1:0]   idxOut
);
  localparam int PW = 3 * DIM_W + 3;

  shape_t           shapeQ;
  logic [DIM_W-1:0] cnt    [3];
  logic [DIM_W-1:0] cntNxt [3];
  logic [DIM_W-1:0] lim    [3];
  logic [5:0]       perm;
  logic [PW-1:0]    xSz, ySz, lin;

  always_comb begin
    lim[0] = shapeQ.xM1;
    lim[1] = shapeQ.yM1;
    lim[2] = shapeQ.zM1;
    perm   = permOf(shapeQ.ord);
  end

  // carry chain in the slot's nesting order
  always_comb begin
    logic carry;
    logic [1:0] d;
    carry = 1'b1;
    for (int k = 0; k < 3; k++) cntNxt[k] = cnt[k];
    for (int p = 0; p < 3; p++) begin
      d = perm[2*p +: 2];
      if (carry) begin
        if (cnt[d] == lim[d]) begin
          cntNxt[d] = '0;
        end else begin
          cntNxt[d] = cnt[d] + DIM_W'(1);
          carry = 1'b0;
        end
      end
    end
  end

  always_comb begin
    xSz = PW'(shapeQ.xM1) + PW'(1);
    ySz = PW'(shapeQ.yM1) + PW'(1);
    lin = PW'(cnt[0]) + PW'(cnt[1]) * xSz + PW'(cnt[2]) * xSz * ySz;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shapeQ <= '0;
      idxOut <= '0;
      for (int k = 0; k < 3; k++) cnt[k] <= '0;
    end else begin
      if (cfgWe && (cfgSlot == SLOT_W'(MY_ID))) shapeQ <= shape_t'(cfgData);
      if (strb.clr) begin
        for (int k = 0; k < 3; k++) cnt[k] <= '0;
      end else if (strb.adv) begin
        idxOut <= shapeQ.en ? IDXW'(lin) : seqCnt;
        for (int k = 0; k < 3; k++) cnt[k] <= cntNxt[k];
      end
    end
  end

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt[0] == '0 && cnt[1] == '0 && cnt[2] == '0));
  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !shapeQ.en) |=> (idxOut == $past(seqCnt)));
endmodule

// File: rtl/remap_top.sv
module remap_top
  import remap_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int IDXW  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [1:0]            cfgSlot,
  input  logic [31:0]           cfgData,
  input  logic                  start,
  input  logic [IDXW-1:0]       vlIn,
  input  logic                  step,
  output logic                  valid,
  output logic                  done,
  output logic [IDXW-1:0]       seqIdx,
  output logic [SLOTS*IDXW-1:0] remapIdx
);
  strb_t           strb;
  logic [IDXW-1:0] seqCnt;

  remap_ctrl #(.IDXW(IDXW)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .step(step), .vlIn(vlIn),
    .strb(strb), .seqCnt(seqCnt), .seqIdx(seqIdx), .valid(valid), .done(done)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    remap_slot #(.IDXW(IDXW), .SLOT_W(2), .MY_ID(s)) i_slot (
      .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot),
      .cfgData(cfgData), .strb(strb), .seqCnt(seqCnt),
      .idxOut(remapIdx[s*IDXW +: IDXW])
    );
  end
endmodule

// File: tb/test_remap_top.sv
module test_remap_top;
  localparam int IDXW = 16;

  logic clk = 0, rstN = 0, cfgWe = 0, start = 0, step = 0;
  logic [1:0] cfgSlot = 0;
  logic [31:0] cfgData = 0;
  logic [IDXW-1:0] vlIn = 0;
  logic valid, done;
  logic [IDXW-1:0] seqIdx;
  logic [4*IDXW-1:0] remapIdx;

  always #4 clk = ~clk;

  remap_top #(.SLOTS(4), .IDXW(IDXW)) i_remap_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgData(cfgData),
    .start(start), .vlIn(vlIn), .step(step), .valid(valid), .done(done),
    .seqIdx(seqIdx), .remapIdx(remapIdx)
  );

  typedef struct packed {
    logic [15:0]      seq;
    logic [3:0][15:0] idx;
    logic             dn;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  int dsz[4][3];
  int ord[4];
  bit en[4];
  int mc[4][3];
  int seqExp, curVl;

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int permDim(int o, int p);
    int t[3];
    case (o)
      1: t = '{0, 2, 1};
      2: t = '{1, 0, 2};
      3: t = '{1, 2, 0};
      4: t = '{2, 0, 1};
      5: t = '{2, 1, 0};
      default: t = '{0, 1, 2};  // R11: codes 6, 7 as 0
    endcase
    return t[p];
  endfunction

  // R1: field layout of the shape word
  task automatic writeCfg(int s, int x, int y, int z, int o, bit e);
    @(negedge clk);
    cfgWe = 1; cfgSlot = 2'(s);
    cfgData = 32'((x-1) | ((y-1) << 7) | ((z-1) << 14) | (o << 21) | (int'(e) << 24))
              | 32'hFE00_0000;  // spare bits set, must be ignored
    dsz[s] = '{x, y, z}; ord[s] = o; en[s] = e;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic doStart(int vl);
    @(negedge clk);
    start = 1; vlIn = IDXW'(vl);
    for (int s = 0; s < 4; s++) mc[s] = '{0, 0, 0};
    seqExp = 0; curVl = vl;
    @(negedge clk);
    start = 0;
  endtask

  task automatic doSteps(int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      @(negedge clk);
      step = 1;
      e.seq = 16'(seqExp);
      e.dn = (seqExp == curVl - 1);
      for (int s = 0; s < 4; s++) begin
        int c;
        // R4 index formula, R7 bypass
        if (en[s]) e.idx[s] = 16'(mc[s][0] + mc[s][1]*dsz[s][0] + mc[s][2]*dsz[s][0]*dsz[s][1]);
        else e.idx[s] = 16'(seqExp);
        c = 1;  // R5 carry chain, R6 unit sizes
        for (int p = 0; p < 3; p++) begin
          int d;
          d = permDim(ord[s], p);
          if (c == 1) begin
            if (mc[s][d] == dsz[s][d] - 1) mc[s][d] = 0;
            else begin mc[s][d]++; c = 0; end
          end
        end
      end
      q.push_back(e);
      seqExp++;
    end
    @(negedge clk);
    step = 0;
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && valid) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(seqIdx == e.seq, "R3 seqIdx", int'(seqIdx), int'(e.seq));
        check(done == e.dn, "R8 done", int'(done), int'(e.dn));
        for (int s = 0; s < 4; s++)
          check(remapIdx[s*IDXW +: IDXW] == e.idx[s], "R4/R5/R9 remapIdx",
                int'(remapIdx[s*IDXW +: IDXW]), int'(e.idx[s]));
      end
    end
  end

  task automatic finishUp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishUp();
  end

  initial begin
    int held;
    for (int s = 0; s < 4; s++) begin dsz[s] = '{1, 1, 1}; ord[s] = 0; en[s] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    check(valid == 0, "R3 reset valid", int'(valid), 0);
    check(done == 0, "R8 reset done", int'(done), 0);
    check(remapIdx == 0, "R1 reset idx", int'(remapIdx[15:0]), 0);

    // R8: step with no loop started is ignored
    @(negedge clk); step = 1; @(negedge clk); step = 0;
    check(valid == 0, "R8 step before start", int'(valid), 0);

    // pattern 1: mixed 2D orders, bypass, 3D reverse order (R9)
    writeCfg(0, 3, 4, 1, 0, 1);
    writeCfg(1, 3, 4, 1, 2, 1);
    writeCfg(2, 5, 5, 5, 3, 0);
    writeCfg(3, 4, 4, 4, 5, 1);
    doStart(12); doSteps(12);

    // R8: steps after done are ignored
    held = int'(seqIdx);
    @(negedge clk); step = 1; @(negedge clk); step = 0;
    check(valid == 0, "R8 step after done", int'(valid), 0);
    check(int'(seqIdx) == held, "R8 seqIdx held", int'(seqIdx), held);

    // pattern 2: R10 matrix walk 4x4x4, 64 steps
    writeCfg(0, 4, 4, 4, 0, 1);
    writeCfg(1, 4, 4, 4, 1, 1);
    writeCfg(2, 4, 4, 4, 3, 1);
    writeCfg(3, 4, 4, 4, 4, 1);
    doStart(64); doSteps(64);

    // pattern 3: R11 spare order codes next to code 0
    writeCfg(0, 2, 3, 2, 6, 1);
    writeCfg(1, 2, 3, 2, 7, 1);
    writeCfg(2, 2, 3, 2, 0, 1);
    writeCfg(3, 2, 3, 2, 4, 1);
    doStart(12); doSteps(12);

    // pattern 4: R6 unit dimensions and wrap past the shape
    writeCfg(0, 2, 1, 2, 0, 1);
    writeCfg(1, 1, 1, 3, 0, 1);
    writeCfg(2, 1, 1, 1, 5, 1);
    writeCfg(3, 2, 2, 1, 2, 0);
    doStart(10); doSteps(10);

    // pattern 5: R2 restart in the middle of a loop
    writeCfg(0, 3, 4, 1, 1, 1);
    writeCfg(3, 3, 2, 2, 3, 1);
    doStart(7); doSteps(3);
    doStart(7); doSteps(7);

    // R8: VL of 0 accepts no steps
    doStart(0);
    @(negedge clk); step = 1; @(negedge clk); step = 0;
    check(valid == 0, "R8 zero length", int'(valid), 0);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R3 missing results", q.size(), 0);
    finishUp();
  end
endmodule